// File: doc/BRIEF.md
# NAND Flash Strobe Sequencer

This block is the host-side engine for an 8-bit asynchronous NAND device with large pages. A small register front end takes byte writes and launches one bus cycle for each. A command byte goes out with the command latch (CLE) high. An address byte goes out with the address latch (ALE) high. A plain data byte goes out with both latches low. A read cycle pulses the read strobe and keeps the byte it sampled for the host to fetch. Three programmable counts shape every cycle, all counted in system clocks:
- a setup stretch before the write strobe falls;
- the width of the active (low) strobe;
- a hold stretch after the strobe rises.

Software builds full page accesses from these single cycles. A page access is one command byte, then five address bytes: two column bytes and three row bytes, with only the two low bits of the last byte in use. The pages are 2048 bytes, with 64 pages to a block and 4096 blocks. A built-in identification sequence runs on its own. It sends command 0x90 and one 0x00 address byte, waits a fixed settling interval, then reads five bytes into a buffer. It raises a one-clock done pulse when the buffer is full. A status register shows the live ready/busy pin. It also holds a sticky flag that records a rising edge on that pin.

Top module: `nand_seq`

## Requirements
- R1: After reset, nCe, nWe and nRe are high, while cle, ale, ioOe, busy and idDone are low. The timing registers read back setup=1 (address 0), active=1 (address 1) and hold=0 (address 2).
- R2: Writing address 4 launches a command cycle. Its shape is as follows:
  - cle is high and ale is low for the whole cycle.
  - nWe stays high for the first S clocks.
  - nWe is then low for exactly A+1 clocks.
  - The cycle ends H+1 clocks later.
  - S, A and H are the setup, active and hold registers.
- R3: Writing address 5 launches an address cycle of the same shape as R2, with ale high and cle low throughout.
- R4: Writing address 6 launches a data write cycle of the same shape as R2, with cle and ale both low.
- R5: ioOe is high exactly while a command, address or data write cycle is in progress, and ioOut then carries the written byte. ioOe is low during reads and while idle.
- R6: Writing address 3 with bit 1 set launches a read cycle. In that cycle:
  - nRe is low for A+1 clocks.
  - ioIn is captured on the last of those clocks.
  - nRe then stays high for H+1 clocks before the cycle ends.
  - The captured byte reads back at address 6.
- R7: busy is high for every clock of a cycle: S+A+H+2 clocks for writes and A+H+2 clocks for reads. Register writes made while busy is high are ignored.
- R8: Bit 0 of the control register (address 3) drives nCe directly. Writing 0 asserts the chip enable (nCe low), and writing 1 releases it.
- R9: The status register is at address 7. Its bit 0 follows the live rnbIn pin (1 means ready), and its bit 1 reads busy.
- R10: Status bit 2 is set by a rising edge on rnbIn and stays set. Writing 1 to bit 2 clears it, and writing 0 leaves it unchanged.
- R11: Writing address 3 with bit 2 set runs the identification sequence:
  - a command cycle carrying 0x90;
  - an address cycle carrying 0x00;
  - an idle gap of H+1+3 clocks with both strobes high;
  - five read cycles, with byte k captured into idBytes[8k+7:8k].
  The sequence lasts 2(S+A+H+2)+3+5(A+H+2) clocks. idDone is high for the single clock in which busy first returns low.
- R12: With the setup register at 0, the write strobe falls in the first clock of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWr | input | 1 | Register write strobe |
| hostAddr | input | 3 | Register address |
| hostWdata | input | 8 | Register write data |
| hostRdata | output | 8 | Register read data for hostAddr |
| busy | output | 1 | A bus cycle or the identification sequence is in progress |
| idBytes | output | 40 | Five captured identification bytes, byte 0 lowest |
| idDone | output | 1 | One-clock pulse at the end of the identification sequence |
| nCe | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| nWe | output | 1 | Write strobe, active low |
| nRe | output | 1 | Read strobe, active low |
| ioOut | output | 8 | Byte driven onto the I/O bus |
| ioOe | output | 1 | Output enable for ioOut |
| ioIn | input | 8 | Byte sampled from the I/O bus |
| rnbIn | input | 1 | Ready/busy pin from the device, 1 means ready |

## Verification
The hardest case to reach from the ports is the read capture point. A correct design and one that samples a clock early both see a steady bus and give the same result. To tell them apart, the bench changes ioIn on every clock of a read cycle to a value that encodes the clock's index. The captured byte then names the exact clock on which it was taken, and this is repeated across every active and hold setting. The identification sequence is checked the same way: a different byte is presented for each read strobe. The silent gap between the address strobe and the first read strobe is measured and compared with the hold count plus the fixed settling interval.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACTIVE, ST_HOLD, ST_REA
  } phase_e;

  typedef enum logic [1:0] {
    K_CMD, K_ADR, K_WDAT, K_RDAT
  } kind_e;

  localparam int         ID_LEN = 5;
  localparam logic [7:0] ID_CMD = 8'h90;

  localparam logic [2:0] A_SETUP  = 3'd0;
  localparam logic [2:0] A_ACTIVE = 3'd1;
  localparam logic [2:0] A_HOLD   = 3'd2;
  localparam logic [2:0] A_CTRL   = 3'd3;
  localparam logic [2:0] A_CMD    = 3'd4;
  localparam logic [2:0] A_ADR    = 3'd5;
  localparam logic [2:0] A_DATA   = 3'd6;
  localparam logic [2:0] A_STAT   = 3'd7;

  // byteSel: 0 host byte, 1 identification command, 2 zero address
  typedef struct packed {
    logic       cle;
    logic       ale;
    logic       weN;
    logic       reN;
    logic       busOe;
    logic       capture;
    logic       idCap;
    logic [2:0] idIdx;
    logic       idDone;
    logic [1:0] byteSel;
  } strobe_t;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int TW       = 4,
  parameter int REA_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrOk,
  input  logic [2:0]    hostAddr,
  input  logic [2:1]    ctrlBits,
  input  logic [TW-1:0] setupT,
  input  logic [TW-1:0] activeT,
  input  logic [TW-1:0] holdT,
  output strobe_t       stb,
  output logic          busy
);
  localparam int RW = $clog2(REA_CLKS + 1);
  localparam int CW = (TW > RW) ? TW : RW;

  phase_e        phase;
  kind_e         kind;
  logic [CW-1:0] cnt;
  logic          idMode;
  logic [2:0]    idStep;

  phase_e        wrPhase;
  logic [CW-1:0] wrCnt;
  logic          startId, startRd, startWr;
  kind_e         wrKind;

  always_comb begin
    wrPhase = (setupT != '0) ? ST_SETUP : ST_ACTIVE;
    wrCnt   = (setupT != '0) ? (CW'(setupT) - CW'(1)) : CW'(activeT);
    startId = wrOk && hostAddr == A_CTRL && ctrlBits[2];
    startRd = wrOk && hostAddr == A_CTRL && ctrlBits[1] && !ctrlBits[2];
    startWr = wrOk && (hostAddr == A_CMD || hostAddr == A_ADR || hostAddr == A_DATA);
    case (hostAddr)
      A_CMD:   wrKind = K_CMD;
      A_ADR:   wrKind = K_ADR;
      default: wrKind = K_WDAT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= ST_IDLE;
      kind   <= K_CMD;
      cnt    <= '0;
      idMode <= 1'b0;
      idStep <= '0;
    end else begin
      case (phase)
        ST_IDLE: begin
          if (startId) begin
            idMode <= 1'b1;
            idStep <= '0;
            kind   <= K_CMD;
            phase  <= wrPhase;
            cnt    <= wrCnt;
          end else if (startWr) begin
            kind  <= wrKind;
            phase <= wrPhase;
            cnt   <= wrCnt;
          end else if (startRd) begin
            kind  <= K_RDAT;
            phase <= ST_ACTIVE;
            cnt   <= CW'(activeT);
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            phase <= ST_ACTIVE;
            cnt   <= CW'(activeT);
          end else cnt <= cnt - 1'b1;
        end
        ST_ACTIVE: begin
          if (cnt == '0) begin
            phase <= ST_HOLD;
            cnt   <= CW'(holdT);
          end else cnt <= cnt - 1'b1;
        end
        ST_HOLD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!idMode) phase <= ST_IDLE;
          else begin
            case (idStep)
              3'd0: begin
                idStep <= 3'd1;
                kind   <= K_ADR;
                phase  <= wrPhase;
                cnt    <= wrCnt;
              end
              3'd1: begin
                idStep <= 3'd2;
                kind   <= K_RDAT;
                phase  <= ST_REA;
                cnt    <= CW'(REA_CLKS - 1);
              end
              3'd6: begin
                idMode <= 1'b0;
                phase  <= ST_IDLE;
              end
              default: begin
                idStep <= idStep + 1'b1;
                phase  <= ST_ACTIVE;
                cnt    <= CW'(activeT);
              end
            endcase
          end
        end
        ST_REA: begin
          if (cnt == '0) begin
            phase <= ST_ACTIVE;
            cnt   <= CW'(activeT);
          end else cnt <= cnt - 1'b1;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  logic inCycle, isWr;
  always_comb begin
    inCycle     = phase == ST_SETUP || phase == ST_ACTIVE || phase == ST_HOLD;
    isWr        = kind != K_RDAT;
    stb.cle     = inCycle && kind == K_CMD;
    stb.ale     = inCycle && kind == K_ADR;
    stb.weN     = !(phase == ST_ACTIVE && isWr);
    stb.reN     = !(phase == ST_ACTIVE && !isWr);
    stb.busOe   = inCycle && isWr;
    stb.capture = phase == ST_ACTIVE && !isWr && cnt == '0;
    stb.idCap   = stb.capture && idMode;
    stb.idIdx   = idStep - 3'd2;
    stb.idDone  = idMode && phase == ST_HOLD && cnt == '0 && idStep == 3'd6;
    stb.byteSel = !idMode ? 2'd0 : ((idStep == 3'd0) ? 2'd1 : 2'd2);
    busy        = phase != ST_IDLE;
  end

  // R2
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(stb.cle && stb.ale));
  // R5
  oe_read_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(stb.busOe && !stb.reN));
  // R6
  capture_last_chk: assert property (@(posedge clk) disable iff (rst)
    stb.capture |=> stb.reN);
  // R7
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb.weN || !stb.reN) |-> busy);

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrOk,
  input  logic [2:0]          hostAddr,
  input  logic [7:0]          hostWdata,
  input  strobe_t             stb,
  input  logic                busy,
  input  logic [7:0]          ioIn,
  input  logic                rnbIn,
  output logic [TW-1:0]       setupT,
  output logic [TW-1:0]       activeT,
  output logic [TW-1:0]       holdT,
  output logic [7:0]          hostRdata,
  output logic [7:0]          ioOut,
  output logic                nCe,
  output logic [8*ID_LEN-1:0] idBytes,
  output logic                idDone
);
  logic       ceOff, sticky, rnbQ;
  logic [7:0] outByte, rdByte;

  always_ff @(posedge clk) begin
    if (rst) begin
      setupT  <= TW'(1);
      activeT <= TW'(1);
      holdT   <= '0;
      ceOff   <= 1'b1;
      outByte <= '0;
    end else if (wrOk) begin
      case (hostAddr)
        A_SETUP:                setupT  <= hostWdata[TW-1:0];
        A_ACTIVE:               activeT <= hostWdata[TW-1:0];
        A_HOLD:                 holdT   <= hostWdata[TW-1:0];
        A_CTRL:                 ceOff   <= hostWdata[0];
        A_CMD, A_ADR, A_DATA:   outByte <= hostWdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rnbQ   <= 1'b1;
      sticky <= 1'b0;
      rdByte <= '0;
      idDone <= 1'b0;
    end else begin
      rnbQ   <= rnbIn;
      idDone <= stb.idDone;
      if (stb.capture) rdByte <= ioIn;
      if (rnbIn && !rnbQ) sticky <= 1'b1;
      else if (wrOk && hostAddr == A_STAT && hostWdata[2]) sticky <= 1'b0;
    end
  end

  for (genvar g = 0; g < ID_LEN; g++) begin : g_idBuf
    logic [7:0] slot;
    always_ff @(posedge clk) begin
      if (rst) slot <= '0;
      else if (stb.idCap && stb.idIdx == 3'(g)) slot <= ioIn;
    end
    assign idBytes[8*g +: 8] = slot;
  end

  always_comb begin
    case (stb.byteSel)
      2'd1:    ioOut = ID_CMD;
      2'd2:    ioOut = 8'h00;
      default: ioOut = outByte;
    endcase
    case (hostAddr)
      A_SETUP:  hostRdata = 8'(setupT);
      A_ACTIVE: hostRdata = 8'(activeT);
      A_HOLD:   hostRdata = 8'(holdT);
      A_CTRL:   hostRdata = {7'b0, ceOff};
      A_DATA:   hostRdata = rdByte;
      A_STAT:   hostRdata = {5'b0, sticky, busy, rnbIn};
      default:  hostRdata = 8'h00;
    endcase
  end

  assign nCe = ceOff;

  // R10
  sticky_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sticky) |-> rnbIn);
  // R11
  id_done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    idDone |-> !busy);
  // R8
  ce_stable_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(nCe));

endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int TW       = 4,
  parameter int REA_CLKS = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hostWr,
  input  logic [2:0]  hostAddr,
  input  logic [7:0]  hostWdata,
  output logic [7:0]  hostRdata,
  output logic        busy,
  output logic [39:0] idBytes,
  output logic        idDone,
  output logic        nCe,
  output logic        cle,
  output logic        ale,
  output logic        nWe,
  output logic        nRe,
  output logic [7:0]  ioOut,
  output logic        ioOe,
  input  logic [7:0]  ioIn,
  input  logic        rnbIn
);
  strobe_t       stb;
  logic          wrOk;
  logic [TW-1:0] setupT, activeT, holdT;

  assign wrOk = hostWr && !busy;

  nand_seq_ctrl #(.TW(TW), .REA_CLKS(REA_CLKS)) u_ctrl (
    .clk(clk), .rst(rst), .wrOk(wrOk), .hostAddr(hostAddr),
    .ctrlBits(hostWdata[2:1]), .setupT(setupT), .activeT(activeT),
    .holdT(holdT), .stb(stb), .busy(busy)
  );

  nand_seq_dp #(.TW(TW)) u_dp (
    .clk(clk), .rst(rst), .wrOk(wrOk), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .stb(stb), .busy(busy), .ioIn(ioIn),
    .rnbIn(rnbIn), .setupT(setupT), .activeT(activeT), .holdT(holdT),
    .hostRdata(hostRdata), .ioOut(ioOut), .nCe(nCe), .idBytes(idBytes),
    .idDone(idDone)
  );

  assign cle  = stb.cle;
  assign ale  = stb.ale;
  assign nWe  = stb.weN;
  assign nRe  = stb.reN;
  assign ioOe = stb.busOe;

endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
  localparam int REA = 3;

  logic        clk = 0, rst = 1, hostWr = 0, rnbIn = 1;
  logic [2:0]  hostAddr = 0;
  logic [7:0]  hostWdata = 0, ioIn = 0;
  logic [7:0]  hostRdata, ioOut;
  logic        busy, idDone, nCe, cle, ale, nWe, nRe, ioOe;
  logic [39:0] idBytes;

  nand_seq u_nand_seq (
    .clk(clk), .rst(rst), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .busy(busy),
    .idBytes(idBytes), .idDone(idDone), .nCe(nCe), .cle(cle), .ale(ale),
    .nWe(nWe), .nRe(nRe), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn),
    .rnbIn(rnbIn)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWr = 1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdata;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  // per-cycle monitor results
  int busyCnt, weLow, weFirst, weLast, reLow, reFirst, reLast;
  int cleAll, cleAny, aleAll, aleAny, oeAll, oeAny, byteOk, statBusy;

  task automatic runCycle(input logic [2:0] a, input logic [7:0] d, input logic [7:0] base);
    int idx;
    busyCnt = 0; weLow = 0; weFirst = -1; weLast = -1; reLow = 0; reFirst = -1; reLast = -1;
    cleAll = 1; cleAny = 0; aleAll = 1; aleAny = 0; oeAll = 1; oeAny = 0; byteOk = 1; statBusy = 1;
    wr(a, d);
    hostAddr = 3'd7;
    idx = 0;
    while (busy) begin
      ioIn = base + 8'(idx);
      #1;
      busyCnt++;
      if (!nWe) begin weLow++; if (weFirst < 0) weFirst = idx; weLast = idx; end
      if (!nRe) begin reLow++; if (reFirst < 0) reFirst = idx; reLast = idx; end
      if (!cle) cleAll = 0; else cleAny = 1;
      if (!ale) aleAll = 0; else aleAny = 1;
      if (!ioOe) oeAll = 0; else begin oeAny = 1; if (ioOut != d) byteOk = 0; end
      if (!hostRdata[1]) statBusy = 0;
      @(negedge clk);
      idx++;
    end
  endtask

  task automatic setTiming(input int s, input int a, input int h);
    wr(3'd0, 8'(s)); wr(3'd1, 8'(a)); wr(3'd2, 8'(h));
  endtask

  function automatic logic [7:0] idPat(input int k);
    return 8'h3C + 8'(k * 37);
  endfunction

  initial begin
    logic [7:0] v;
    string tag;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 nCe", nCe, 1); chk("R1 nWe", nWe, 1); chk("R1 nRe", nRe, 1);
    chk("R1 cle", cle, 0); chk("R1 ale", ale, 0); chk("R1 ioOe", ioOe, 0);
    chk("R1 busy", busy, 0); chk("R1 idDone", idDone, 0);
    rd(3'd0, v); chk("R1 setup", v, 1);
    rd(3'd1, v); chk("R1 active", v, 1);
    rd(3'd2, v); chk("R1 hold", v, 0);

    // R8 chip enable
    wr(3'd3, 8'h00); #1 chk("R8 nCe asserted", nCe, 0);
    wr(3'd3, 8'h01); #1 chk("R8 nCe released", nCe, 1);
    wr(3'd3, 8'h00);

    // R2 / R12 / R5 / R7 command sweep
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 4; a++)
        for (int h = 0; h < 3; h++) begin
          setTiming(s, a, h);
          runCycle(3'd4, 8'(8'hA5 ^ (s * 16 + a * 4 + h)), 8'h00);
          tag = (s == 0) ? "R12" : "R2";
          chk({tag, " nWe first low"}, weFirst, s);
          chk({tag, " nWe low count"}, weLow, a + 1);
          chk({tag, " nWe last low"}, weLast, s + a);
          chk("R2 cle whole cycle", cleAll, 1);
          chk("R2 ale never", aleAny, 0);
          chk("R7 busy length", busyCnt, s + a + h + 2);
          chk("R5 oe whole cycle", oeAll, 1);
          chk("R5 byte driven", byteOk, 1);
          chk("R9 status busy bit", statBusy, 1);
          chk("R5 nRe quiet", reLow, 0);
        end

    // R3 address sweep and R4 data sweep
    for (int a = 0; a < 4; a++)
      for (int h = 0; h < 3; h++) begin
        setTiming(2, a, h);
        runCycle(3'd5, 8'(a * 3 + h), 8'h00);
        chk("R3 ale whole cycle", aleAll, 1);
        chk("R3 cle never", cleAny, 0);
        chk("R3 nWe low count", weLow, a + 1);
        chk("R3 nWe first low", weFirst, 2);
        chk("R3 byte driven", byteOk, 1);
        runCycle(3'd6, 8'(8'hF0 - a - h), 8'h00);
        chk("R4 cle never", cleAny, 0);
        chk("R4 ale never", aleAny, 0);
        chk("R4 nWe low count", weLow, a + 1);
        chk("R4 busy length", busyCnt, a + h + 4);
        chk("R4 oe and byte", oeAll & byteOk, 1);
      end

    // R6 read sweep
    for (int a = 0; a < 4; a++)
      for (int h = 0; h < 3; h++) begin
        setTiming(1, a, h);
        runCycle(3'd3, 8'h02, 8'(16 * (a + 1) + h));
        chk("R6 nRe first low", reFirst, 0);
        chk("R6 nRe low count", reLow, a + 1);
        chk("R6 busy length", busyCnt, a + h + 2);
        chk("R5 oe off in read", oeAny, 0);
        chk("R6 nWe quiet", weLow, 0);
        rd(3'd6, v);
        chk("R6 captured byte", v, 16 * (a + 1) + h + a);
      end

    // R7 writes ignored while busy
    setTiming(3, 3, 2);
    wr(3'd4, 8'h11);
    hostWr = 1; hostAddr = 3'd0; hostWdata = 8'h05;
    repeat (3) @(negedge clk);
    hostWr = 0;
    waitIdle();
    rd(3'd0, v); chk("R7 setup unchanged", v, 3);

    // R9 live pin, R10 sticky flag
    rnbIn = 0;
    rd(3'd7, v); chk("R9 live pin low", v[0], 0);
    chk("R10 no edge yet", v[2], 0);
    rnbIn = 1;
    @(negedge clk);
    rd(3'd7, v); chk("R9 live pin high", v[0], 1);
    chk("R10 edge captured", v[2], 1);
    wr(3'd7, 8'h00);
    rd(3'd7, v); chk("R10 write 0 keeps", v[2], 1);
    wr(3'd7, 8'h04);
    rd(3'd7, v); chk("R10 write 1 clears", v[2], 0);
    repeat (2) @(negedge clk);
    rd(3'd7, v); chk("R10 stays clear", v[2], 0);

    // R11 identification sequence with defaults
    setTiming(1, 1, 0);
    begin
      int idx, weRuns, reRuns, lastWe, firstRe, doneCnt;
      logic pWe, pRe;
      logic [7:0] wByte [2];
      logic wCle [2], wAle [2];
      idx = 0; weRuns = 0; reRuns = 0; lastWe = -1; firstRe = -1; doneCnt = 0;
      pWe = 1; pRe = 1;
      wr(3'd3, 8'h04);
      while (busy) begin
        ioIn = idPat(reRuns);
        #1;
        if (!nWe && pWe) begin
          if (weRuns < 2) begin wByte[weRuns] = ioOut; wCle[weRuns] = cle; wAle[weRuns] = ale; end
          weRuns++;
        end
        if (!nWe) lastWe = idx;
        if (!nRe && firstRe < 0) firstRe = idx;
        if (nRe && !pRe) reRuns++;
        if (idDone) doneCnt++;
        pWe = nWe; pRe = nRe;
        @(negedge clk);
        idx++;
      end
      #1;
      chk("R11 done at end", idDone, 1);
      chk("R11 done not early", doneCnt, 0);
      chk("R11 total length", idx, 2 * 4 + REA + 5 * 3);
      chk("R11 write strobes", weRuns, 2);
      chk("R11 cmd byte", wByte[0], 8'h90);
      chk("R11 cmd cle", wCle[0] & !wAle[0], 1);
      chk("R11 addr byte", wByte[1], 8'h00);
      chk("R11 addr ale", wAle[1] & !wCle[1], 1);
      chk("R11 settle gap", firstRe - lastWe - 1, 1 + REA);
      chk("R11 read strobes", reRuns, 5);
      for (int k = 0; k < 5; k++) chk("R11 id byte", idBytes[8*k +: 8], idPat(k));
      @(negedge clk); #1;
      chk("R11 done single pulse", idDone, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule